// File: doc/BRIEF.md
# Checkerboard-Run Memory Self-Test Controller

This block is a built-in self-test engine for a single-port, byte-wide memory whose size is a power of two. It walks a fixed list of test steps. Each step has an 8-bit background value and a run length. In every step the engine first writes the whole memory, from address 0 upward. It writes the background value across the first run of addresses, then its complement across the next run, and keeps alternating in this way. It then reads the memory back in the same order and rebuilds the same alternating sequence to compare each byte. Short runs expose bit-to-bit coupling inside a byte. Long runs of all-ones and all-zeros, doubling in length, expose address lines that are stuck or shorted.

The engine is destructive: the memory contents are lost. A single start pulse launches the whole sequence. busy stays high while it runs. A mismatch never stops the test. It sets an internal sticky error, which is placed on the fail output when the last step ends, together with a one-cycle done pulse. A keep-alive output toggles at a steady rate while the engine walks memory, so that an external supervisor can see that the test is still making progress.

Top module: `ram_run_bist`

## Requirements
- R1: When idle, a start pulse raises busy_o in the next cycle. A start pulse received while busy has no effect on the address/data sequence or on the run length.
- R2: The steps run in this order: background values AA, 55, CC, 33, F0, 0F, FF, 00, each with run length 1. Then come FF and 00 at run lengths 2, 4, 8, 16, 32, 64, 128 and 256, each length used twice. Any step whose run length exceeds the memory size (2^ADDR_W) is skipped. At the default ADDR_W=7 this gives 22 steps.
- R3: Within a pass, mem_addr_o starts at 0 and rises by one each cycle up to 2^ADDR_W-1. The byte used at address a equals the step value XOR FF when floor(a / run) is odd, and the step value itself otherwise.
- R4: Each step is one write pass, in which mem_we_o=1 for 2^ADDR_W cycles, followed by one read pass, in which mem_we_o=0 for 2^ADDR_W cycles. The read pass expects the same byte sequence as the write pass. Read data is compared one cycle after its address is driven.
- R5: Run length is held in an 8-bit field, and the value 256 is stored as 0. With ADDR_W=8, the last two steps write FF to all 256 addresses and then 00 to all 256 addresses.
- R6: Any compare mismatch sets a sticky error and the sequence still runs to the end. fail_o takes the final error value when done_o rises, holds it while idle, and returns to 0 in the cycle after a start is accepted.
- R7: done_o is high for exactly one cycle, and it rises in the same cycle that busy_o falls. busy_o stays high for (steps × 2 × 2^ADDR_W) + 1 cycles.
- R8: keepalive_o toggles on every address step that moves the address counter onto a multiple of 32, the wrap to 0 included. This gives 2^ADDR_W/32 toggles per pass.
- R9: With a fault-free memory fail_o ends at 0. It ends at 1 for each of three memory faults: a bit stuck at 0 in the top address, an address line stuck at 0, and a write to one cell that disturbs one bit of its neighbour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a test run (used only when idle) |
| busy_o | output | 1 | Test sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of the run |
| fail_o | output | 1 | Result of the last run, 1 = mismatch seen |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after the address |
| keepalive_o | output | 1 | Toggles as the address counter crosses multiples of 32 |

## Verification
Because the compare is pipelined, the check of the last byte read in a step falls in the same cycle as the first write of the next step. The bench provokes this with a stuck bit placed at the top address, so the mismatch has to be caught while the write to address 0 is under way. It is judged by requiring fail_o=1 at done_o and by requiring the scoreboard's write stream to stay intact. A second collision is the address wrap at the end of a pass, which both reloads the run state and toggles the keep-alive. It is judged by the exact toggle count and by the expected byte at address 0 of the following pass.

// File: rtl/ram_run_bist_pkg.sv
package ram_run_bist_pkg;

  localparam int unsigned TABLE_LEN = 24;
  localparam int unsigned IDX_W     = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_DRAIN
  } bist_st_e;

  // background byte of table entry idx
  function automatic logic [7:0] step_pat(input int unsigned idx);
    logic [7:0] p;
    case (idx)
      0: p = 8'hAA;
      1: p = 8'h55;
      2: p = 8'hCC;
      3: p = 8'h33;
      4: p = 8'hF0;
      5: p = 8'h0F;
      6: p = 8'hFF;
      7: p = 8'h00;
      default: p = (idx % 2 == 0) ? 8'hFF : 8'h00;
    endcase
    return p;
  endfunction

  // log2 of the run length of table entry idx
  function automatic int unsigned step_log(input int unsigned idx);
    return (idx < 8) ? 0 : ((idx - 8) / 2) + 1;
  endfunction

  // run length in an 8-bit field, 256 encoded as 0
  function automatic logic [7:0] step_run(input int unsigned idx);
    logic [8:0] r;
    r = 9'd1 << step_log(idx);
    return r[7:0];
  endfunction

  // entries whose run fits a memory of 2^aw bytes
  function automatic int unsigned step_count(input int unsigned aw);
    int unsigned n;
    n = 0;
    for (int unsigned i = 0; i < TABLE_LEN; i++)
      if (step_log(i) <= aw) n++;
    return n;
  endfunction

endpackage

// File: rtl/ram_run_bist_steps.sv
module ram_run_bist_steps
  import ram_run_bist_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       first_i,
  input  logic       next_i,
  output logic [7:0] cur_pat_o,
  output logic [7:0] cur_run_o,
  output logic [7:0] nxt_pat_o,
  output logic [7:0] nxt_run_o,
  output logic       last_o
);

  localparam int unsigned NUM_STEPS = step_count(ADDR_W);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (first_i) idx_q <= '0;
    else if (next_i)  idx_q <= idx_q + 1'b1;
  end

  assign cur_pat_o = step_pat(int'(idx_q));
  assign cur_run_o = step_run(int'(idx_q));
  assign nxt_pat_o = step_pat(int'(idx_q) + 1);
  assign nxt_run_o = step_run(int'(idx_q) + 1);
  assign last_o    = (int'(idx_q) == NUM_STEPS - 1);

  // R2
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idx_q) < NUM_STEPS);

endmodule

// File: rtl/ram_run_bist_walker.sv
module ram_run_bist_walker #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned KA_LOG = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [7:0]        seed_pat_i,
  input  logic [7:0]        seed_run_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        data_o,
  output logic              wrap_o,
  output logic              keepalive_o
);

  localparam int unsigned KA_W = (KA_LOG < ADDR_W) ? KA_LOG : ADDR_W;

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_nxt;
  logic [7:0]        data_q, cnt_q, run_q;
  logic              ka_q;
  logic              at_top;

  assign addr_nxt = addr_q + 1'b1;
  assign at_top   = (addr_q == '1);
  assign wrap_o   = adv_i && at_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
      run_q  <= '0;
      ka_q   <= 1'b0;
    end else if (load_i) begin
      addr_q <= '0;
      data_q <= seed_pat_i;
      cnt_q  <= seed_run_i;
      run_q  <= seed_run_i;
    end else if (adv_i) begin
      addr_q <= addr_nxt;
      if (addr_nxt[KA_W-1:0] == '0) ka_q <= ~ka_q;
      if (at_top) begin
        // next pass restarts from the table value
        data_q <= seed_pat_i;
        cnt_q  <= seed_run_i;
        run_q  <= seed_run_i;
      end else if (cnt_q == 8'd1) begin
        data_q <= ~data_q;
        cnt_q  <= run_q;
      end else begin
        // a field of 0 wraps to 255 and so spans 256 addresses
        cnt_q <= cnt_q - 8'd1;
      end
    end
  end

  assign addr_o      = addr_q;
  assign data_o      = data_q;
  assign keepalive_o = ka_q;

  // R8
  ka_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ka_q != $past(ka_q)) |-> (addr_q[KA_W-1:0] == '0));

  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !at_top) |=> (addr_q != '0));

endmodule

// File: rtl/ram_run_bist_cmp.sv
module ram_run_bist_cmp (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       chk_i,
  input  logic [7:0] exp_i,
  input  logic [7:0] rdata_i,
  output logic       err_o
);

  logic       chk_q;
  logic [7:0] exp_q;
  logic       err_q;
  logic       miss;

  assign miss = chk_q && (rdata_i != exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_q <= 1'b0;
      exp_q <= '0;
      err_q <= 1'b0;
    end else begin
      chk_q <= chk_i;
      exp_q <= exp_i;
      if (clear_i)   err_q <= 1'b0;
      else if (miss) err_q <= 1'b1;
    end
  end

  assign err_o = err_q | miss;

  // R6
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clear_i) |=> err_q);

endmodule

// File: rtl/ram_run_bist.sv
module ram_run_bist
  import ram_run_bist_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned KA_LOG = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              keepalive_o
);

  bist_st_e   state_q;
  logic       done_q, fail_q;
  logic       launch, adv, wrap, last_step, err;
  logic [7:0] cur_pat, cur_run, nxt_pat, nxt_run;
  logic [7:0] seed_pat, seed_run, walk_data;

  assign launch = (state_q == ST_IDLE) && start_i;
  assign adv    = (state_q == ST_WRITE) || (state_q == ST_READ);

  always_comb begin
    case (state_q)
      ST_READ:  begin seed_pat = nxt_pat;     seed_run = nxt_run;     end
      ST_WRITE: begin seed_pat = cur_pat;     seed_run = cur_run;     end
      default:  begin seed_pat = step_pat(0); seed_run = step_run(0); end
    endcase
  end

  ram_run_bist_steps #(.ADDR_W(ADDR_W)) u_steps (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .first_i   (launch),
    .next_i    ((state_q == ST_READ) && wrap && !last_step),
    .cur_pat_o (cur_pat),
    .cur_run_o (cur_run),
    .nxt_pat_o (nxt_pat),
    .nxt_run_o (nxt_run),
    .last_o    (last_step)
  );

  ram_run_bist_walker #(.ADDR_W(ADDR_W), .KA_LOG(KA_LOG)) u_walker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (launch),
    .adv_i       (adv),
    .seed_pat_i  (seed_pat),
    .seed_run_i  (seed_run),
    .addr_o      (mem_addr_o),
    .data_o      (walk_data),
    .wrap_o      (wrap),
    .keepalive_o (keepalive_o)
  );

  ram_run_bist_cmp u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (launch),
    .chk_i   (state_q == ST_READ),
    .exp_i   (walk_data),
    .rdata_i (mem_rdata_i),
    .err_o   (err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_WRITE;
          fail_q  <= 1'b0;
        end
        ST_WRITE: if (wrap) state_q <= ST_READ;
        ST_READ:  if (wrap) state_q <= last_step ? ST_DRAIN : ST_WRITE;
        default: begin
          // last read byte is compared in this cycle
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          fail_q  <= err;
        end
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_wdata_o = walk_data;

  // R7
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  we_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  // R1
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != ST_DRAIN) |=> busy_o);

  // R6
  fail_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(fail_o));

endmodule

// File: tb/ram_run_bist_bench.sv
module ram_run_bist_bench;

  localparam int AW    = 7;
  localparam int N     = 1 << AW;
  localparam int STEPS = 22;
  localparam int N8    = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // main instance
  logic          start, busy, done, fail, we, ka;
  logic [AW-1:0] addr;
  logic [7:0]    wdata, rdata;

  ram_run_bist #(.ADDR_W(AW)) u_ram_run_bist (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .fail_o(fail), .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_we_o(we),
    .mem_rdata_i(rdata), .keepalive_o(ka)
  );

  // memory model with injectable faults: 0 none, 1 stuck bit, 2 alias, 3 coupling
  int            fault = 0;
  logic [7:0]    mem [N];
  logic [AW-1:0] ea;
  always @(posedge clk) begin
    ea = (fault == 2) ? (addr & ~AW'(32)) : addr;
    if (we) begin
      mem[ea] <= wdata;
      if (fault == 3 && addr == AW'(21)) mem[20][2] <= wdata[2];
    end
    rdata <= (fault == 1 && ea == AW'(N - 1)) ? (mem[ea] & 8'hFE) : mem[ea];
  end

  // second instance covering the 256-byte case
  logic          start8, busy8, done8, fail8, we8, ka8;
  logic [7:0]    addr8, wdata8, rdata8;
  logic [7:0]    mem8 [N8];

  ram_run_bist #(.ADDR_W(8)) u_ram_run_bist_w8 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start8), .busy_o(busy8), .done_o(done8),
    .fail_o(fail8), .mem_addr_o(addr8), .mem_wdata_o(wdata8), .mem_we_o(we8),
    .mem_rdata_i(rdata8), .keepalive_o(ka8)
  );

  always @(posedge clk) begin
    if (we8) mem8[addr8] <= wdata8;
    rdata8 <= mem8[addr8];
  end

  // scoreboard
  logic [14:0] exp_q[$];

  function automatic logic [7:0] tbl_pat(input int s);
    logic [7:0] base [8] = '{8'hAA, 8'h55, 8'hCC, 8'h33, 8'hF0, 8'h0F, 8'hFF, 8'h00};
    if (s < 8) return base[s];
    return (s % 2 == 0) ? 8'hFF : 8'h00;
  endfunction

  function automatic int tbl_run(input int s);
    return (s < 8) ? 1 : (1 << ((s - 8) / 2 + 1));
  endfunction

  task automatic push_expected();
    for (int s = 0; s < STEPS; s++)
      for (int a = 0; a < N; a++)
        exp_q.push_back({AW'(a), tbl_pat(s) ^ ((((a / tbl_run(s)) % 2) == 1) ? 8'hFF : 8'h00)});
  endtask

  always @(negedge clk) begin
    if (rst_n && we) begin
      if (exp_q.size() == 0) check(1'b0, "R4 extra write", int'(addr), -1);
      else begin
        logic [14:0] e;
        e = exp_q.pop_front();
        // R2 R3: address and byte of each write
        check({addr, wdata} == e, "R3 write addr/data", int'({addr, wdata}), int'(e));
      end
    end
  end

  int w8_cnt = 0;
  int w8_bad = 0;
  always @(negedge clk) begin
    if (rst_n && we8) begin
      if (w8_cnt >= 22 * N8)
        if (wdata8 != ((w8_cnt < 23 * N8) ? 8'hFF : 8'h00)) w8_bad++;
      w8_cnt++;
    end
  end

  task automatic run_main(input int mode, input bit exp_fail, input bit restart);
    int  nb, nk, cyc;
    logic ka_prev;
    bit  seen;
    fault = mode;
    push_expected();
    ka_prev = ka;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    check(fail == 1'b0, "R6 fail cleared at start", int'(fail), 0);
    nb = 1; nk = 0; seen = 0;
    if (ka != ka_prev) nk++;
    ka_prev = ka;
    for (cyc = 0; cyc < 20000; cyc++) begin
      if (restart && cyc == 1000) start = 1'b1;
      if (restart && cyc == 1001) start = 1'b0;
      @(negedge clk);
      if (ka != ka_prev) nk++;
      ka_prev = ka;
      if (busy) nb++;
      if (done) begin
        seen = 1;
        check(busy == 1'b0, "R7 busy falls with done", int'(busy), 0);
        break;
      end
    end
    check(seen, "R7 watchdog: done seen", int'(seen), 1);
    check(nb == STEPS * 2 * N + 1, "R7 busy length", nb, STEPS * 2 * N + 1);
    check(nk == STEPS * 2 * N / 32, "R8 keepalive toggles", nk, STEPS * 2 * N / 32);
    check(exp_q.size() == 0, "R2 all writes seen", exp_q.size(), 0);
    check(fail == exp_fail, $sformatf("R9 fail with fault %0d", mode), int'(fail), int'(exp_fail));
    if (restart) check(1'b1, "R1 restart ignored (seq/len above)", 1, 1);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    check(fail == exp_fail, "R6 fail held while idle", int'(fail), int'(exp_fail));
    exp_q.delete();
  endtask

  initial begin
    int cyc;
    start = 1'b0;
    start8 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, fail, we, ka} == 5'b0, "R1 reset state", int'({busy, done, fail, we, ka}), 0);

    run_main(0, 1'b0, 1'b1);  // R1 R9 fault-free with start while busy
    run_main(1, 1'b1, 1'b0);  // R9 stuck bit at top address
    run_main(2, 1'b1, 1'b0);  // R9 address line stuck
    run_main(3, 1'b1, 1'b0);  // R9 neighbour coupling
    run_main(0, 1'b0, 1'b0);  // R6 fail returns to 0

    // R5 256-byte memory
    start8 = 1'b1;
    @(negedge clk);
    start8 = 1'b0;
    for (cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      if (done8) break;
    end
    check(done8 == 1'b1, "R5 watchdog: done seen", int'(done8), 1);
    check(w8_cnt == 24 * N8, "R5 write count", w8_cnt, 24 * N8);
    check(w8_bad == 0, "R5 run-256 steps solid", w8_bad, 0);
    check(fail8 == 1'b0, "R5 fail clean", int'(fail8), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule